// File: doc/BRIEF.md
# DMA Interrupt Status and Summary Register

This block holds the interrupt causes of a network controller's DMA engine. The transmit and receive processes signal events with single-cycle pulses. Each pulse sets a sticky cause bit. The host reads the status word and acknowledges causes by writing ones back to them. A companion enable word uses the same bit layout. Only enabled causes reach the two derived summary bits: one summary for routine events and one for error events. A registered interrupt line goes high when a summary is active and that summary's own enable is set. The host services events in a loop until neither summary bit reads as set.

The status word also carries read-only information. Two 3-bit fields show the live state codes of the receive and transmit processes. A 3-bit error-type field holds the error code captured with the most recent fatal bus error. Register access goes through a simple port: one select bit picks the status word (0) or the enable word (1). Writes happen on the cycles where the write strobe is high. Read data is combinational.

Top module: `dma_irq_status`

## Requirements
- R1: When reset is released, every cause bit, both summaries, the error-type field and the whole enable word read as zero, and the interrupt line is low.
- R2: A pulse on event input bit n sets cause bit n. The cause bits are transmit done (0), transmit stopped (1), transmit buffer unavailable (2), transmit jabber timeout (3), transmit underflow (5), receive done (6), receive buffer unavailable (7), receive stopped (8), receive watchdog timeout (9), early transmit (10), timer expired (11) and fatal bus error (13). A set bit stays set until the host clears it.
- R3: A status write (select 0) clears every cause bit written as 1 and leaves every bit written as 0 unchanged. Writing back the value just read therefore clears every cause seen in that read.
- R4: If an event pulse and a clearing write hit the same cause bit in the same cycle, the bit remains set.
- R5: An enable write (select 1) stores the cause positions and bits 15 and 16. A read with select 1 returns the stored word, with every other position reading zero.
- R6: Bit 16 of the status word (normal summary) reads 1 exactly when any of causes 0, 2, 6 or 10 is both set and enabled.
- R7: Bit 15 of the status word (abnormal summary) reads 1 exactly when any of causes 1, 3, 5, 7, 8, 9, 11 or 13 is both set and enabled.
- R8: Bits 19:17 of the status word show the receive state input. Bits 22:20 show the transmit state input. Both follow their inputs without delay, and writes to these bits have no effect.
- R9: Bits 25:23 of the status word hold the error code that was present on the cycle of a fatal-bus-error event. The field keeps that value while cause 13 stays set. It returns to zero when cause 13 is cleared without a new fatal event in the same cycle.
- R10: The interrupt line is a register. On each cycle it shows the value, from the previous cycle, of (normal summary AND enable bit 16) OR (abnormal summary AND enable bit 15).
- R11: Bits 4, 12, 14 and 26 to 31 of the status word always read zero, and event pulses or writes at those positions have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected word |
| addr | input | 1 | Word select: 0 selects status, 1 selects enable |
| wr_data | input | 32 | Write data; on the status word a 1 clears the bit |
| ev_pulse | input | 32 | Single-cycle event pulses in the status bit layout |
| rx_state | input | 3 | Live receive process state code |
| tx_state | input | 3 | Live transmit process state code |
| err_code | input | 3 | Error type, captured on a fatal bus error event |
| rd_data | output | 32 | Read data of the selected word |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write and an event pulse landing on the same bit in the same cycle. The case must then be checked together with the summaries and the error-type capture that depend on it. Directed steps place an all-ones clearing write in the same cycle as a single event pulse, and place a fatal event next to a clear of its own bit. A long run of random writes, enables and pulses then checks every cycle against a behavioural model. That run meets many same-cycle overlaps on every bit and also covers the one-cycle lag of the interrupt line.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int REG_W = 32;
    localparam int ST_W  = 3;

    // Cause positions: the host's software decodes these.
    localparam int B_TXDONE  = 0;
    localparam int B_TXSTOP  = 1;
    localparam int B_TXNOBUF = 2;
    localparam int B_TXJAB   = 3;
    localparam int B_TXUNF   = 5;
    localparam int B_RXDONE  = 6;
    localparam int B_RXNOBUF = 7;
    localparam int B_RXSTOP  = 8;
    localparam int B_RXWDT   = 9;
    localparam int B_TXEARLY = 10;
    localparam int B_TIMER   = 11;
    localparam int B_BUSERR  = 13;

    // Derived and read-only fields.
    localparam int B_ABN  = 15;
    localparam int B_NRM  = 16;
    localparam int B_RXST = 17;
    localparam int B_TXST = 20;
    localparam int B_ERR  = 23;

    typedef logic [REG_W-1:0] word_t;
    typedef logic [ST_W-1:0]  code_t;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } sel_e;

    function automatic word_t bit_at(input int pos);
        return word_t'(1) << pos;
    endfunction

    localparam word_t NORMAL_MASK =
        bit_at(B_TXDONE) | bit_at(B_TXNOBUF) | bit_at(B_RXDONE) | bit_at(B_TXEARLY);

    localparam word_t ABNORMAL_MASK =
        bit_at(B_TXSTOP) | bit_at(B_TXJAB) | bit_at(B_TXUNF) | bit_at(B_RXNOBUF) |
        bit_at(B_RXSTOP) | bit_at(B_RXWDT) | bit_at(B_TIMER) | bit_at(B_BUSERR);

    localparam word_t CAUSE_MASK  = NORMAL_MASK | ABNORMAL_MASK;
    localparam word_t ENABLE_MASK = CAUSE_MASK | bit_at(B_ABN) | bit_at(B_NRM);

    // The pieces that make up one status read.
    typedef struct packed {
        code_t err;
        code_t txst;
        code_t rxst;
        logic  nrm;
        logic  abn;
        word_t cause;
    } status_view_t;

    function automatic word_t pack_status(input status_view_t v);
        word_t w;
        w = v.cause & CAUSE_MASK;
        w = w | (word_t'(v.abn)  << B_ABN);
        w = w | (word_t'(v.nrm)  << B_NRM);
        w = w | (word_t'(v.rxst) << B_RXST);
        w = w | (word_t'(v.txst) << B_TXST);
        w = w | (word_t'(v.err)  << B_ERR);
        return w;
    endfunction

endpackage

// File: rtl/isr_cause_bank.sv
module isr_cause_bank
    import isr_pkg::*;
#(
    parameter word_t VALID = CAUSE_MASK
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t set_vec,
    input  word_t clr_vec,
    output word_t cause_q
);
    localparam int W = $bits(word_t);

    // One sticky flop per valid position; a set wins over a clear.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (set_vec[i])
                    bit_q <= 1'b1;
                else if (clr_vec[i])
                    bit_q <= 1'b0;
            end
            assign cause_q[i] = bit_q;
        end else begin : g_tie
            assign cause_q[i] = 1'b0;
        end
    end

    // Positions with no flop still consume their inputs.
    logic spare_unused;
    assign spare_unused = ^((set_vec | clr_vec) & ~VALID);
endmodule

// File: rtl/isr_summary.sv
module isr_summary
    import isr_pkg::*;
(
    input  word_t cause_q,
    input  word_t en_q,
    output logic  nrm,
    output logic  abn
);
    word_t live;
    assign live = cause_q & en_q;
    assign nrm  = |(live & NORMAL_MASK);
    assign abn  = |(live & ABNORMAL_MASK);
endmodule

// File: rtl/isr_err_capture.sv
module isr_err_capture
    import isr_pkg::*;
#(
    parameter int TRIG = B_BUSERR
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  trig_set,
    input  logic  trig_clr,
    input  code_t code_in,
    output code_t code_q
);
    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (trig_set)
            code_q <= code_in;
        else if (trig_clr)
            code_q <= '0;
    end

    // Keeps the trigger position visible to readers of this module.
    localparam int TRIG_POS = TRIG;
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import isr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [REG_W-1:0]   ev_pulse,
    input  logic [ST_W-1:0]    rx_state,
    input  logic [ST_W-1:0]    tx_state,
    input  logic [ST_W-1:0]    err_code,
    output logic [REG_W-1:0]   rd_data,
    output logic               irq
);
    sel_e  sel;
    word_t clr_vec;
    word_t set_vec;
    word_t cause_q;
    word_t en_q;
    code_t err_q;
    logic  nis;
    logic  ais;
    logic  irq_q;

    assign sel     = sel_e'(addr);
    assign clr_vec = (wr_en && sel == SEL_STATUS) ? wr_data : '0;
    assign set_vec = ev_pulse;

    isr_cause_bank #(.VALID(CAUSE_MASK)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .cause_q (cause_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en && sel == SEL_ENABLE)
            en_q <= wr_data & ENABLE_MASK;
    end

    isr_summary u_sum (
        .cause_q (cause_q),
        .en_q    (en_q),
        .nrm     (nis),
        .abn     (ais)
    );

    isr_err_capture #(.TRIG(B_BUSERR)) u_err (
        .clk      (clk),
        .rst      (rst),
        .trig_set (set_vec[B_BUSERR]),
        .trig_clr (clr_vec[B_BUSERR]),
        .code_in  (err_code),
        .code_q   (err_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= (nis & en_q[B_NRM]) | (ais & en_q[B_ABN]);
    end
    assign irq = irq_q;

    status_view_t view;
    always_comb begin
        view.cause = cause_q;
        view.abn   = ais;
        view.nrm   = nis;
        view.rxst  = rx_state;
        view.txst  = tx_state;
        view.err   = err_q;
    end

    assign rd_data = (sel == SEL_ENABLE) ? en_q : pack_status(view);
endmodule

// File: rtl/isr_checker.sv
module isr_checker
    import isr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_en,
    input logic  addr,
    input word_t wr_data,
    input word_t ev_pulse,
    input word_t rd_data,
    input logic  irq,
    input word_t cause_q,
    input word_t en_q,
    input logic  nis,
    input logic  ais
);
    localparam word_t READ_MASK = ENABLE_MASK | (word_t'(9'h1FF) << B_RXST);

    word_t clr_w;
    assign clr_w = (wr_en && !addr) ? wr_data : '0;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && cause_q == '0 && en_q == '0)); // R1

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (($past(cause_q) & ~$past(clr_w) & ~cause_q) == '0)); // R3

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((($past(ev_pulse) & CAUSE_MASK) & ~cause_q) == '0)); // R4

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
        irq == $past((nis & en_q[B_NRM]) | (ais & en_q[B_ABN]))); // R10

    AST_NO_STRAY_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~READ_MASK) == '0); // R11
endmodule

bind dma_irq_status isr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .ev_pulse (ev_pulse),
    .rd_data  (rd_data),
    .irq      (irq),
    .cause_q  (cause_q),
    .en_q     (en_q),
    .nis      (nis),
    .ais      (ais)
);

// File: tb/test_dma_irq_status.sv
module test_dma_irq_status;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ev_pulse = '0;
    logic [2:0]  rx_state = '0;
    logic [2:0]  tx_state = '0;
    logic [2:0]  err_code = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    dma_irq_status i_dma_irq_status (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .ev_pulse(ev_pulse), .rx_state(rx_state), .tx_state(tx_state),
        .err_code(err_code), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model.
    int normal_bits[4]   = '{0, 2, 6, 10};
    int abnormal_bits[8] = '{1, 3, 5, 7, 8, 9, 11, 13};
    bit m_cause[32];
    bit m_en[32];
    int m_err;
    bit m_irq;

    function automatic bit is_cause(int b);
        foreach (normal_bits[k]) if (normal_bits[k] == b) return 1;
        foreach (abnormal_bits[k]) if (abnormal_bits[k] == b) return 1;
        return 0;
    endfunction

    function automatic bit m_nis();
        foreach (normal_bits[k]) if (m_cause[normal_bits[k]] && m_en[normal_bits[k]]) return 1;
        return 0;
    endfunction

    function automatic bit m_ais();
        foreach (abnormal_bits[k]) if (m_cause[abnormal_bits[k]] && m_en[abnormal_bits[k]]) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] exp_read();
        logic [31:0] w = '0;
        if (addr) begin
            for (int b = 0; b < 32; b++) if (m_en[b]) w[b] = 1'b1;
        end else begin
            for (int b = 0; b < 32; b++) if (m_cause[b]) w[b] = 1'b1;
            w[15] = m_ais();
            w[16] = m_nis();
            w = w + (32'(rx_state) * 32'h20000) + (32'(tx_state) * 32'h100000)
                  + (32'(m_err) * 32'h800000);
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 32; b++) begin m_cause[b] = 0; m_en[b] = 0; end
            m_err = 0;
            m_irq = 0;
        end else begin
            bit nxt_irq;
            nxt_irq = (m_nis() && m_en[16]) || (m_ais() && m_en[15]);
            if (wr_en && addr) begin
                for (int b = 0; b < 32; b++)
                    m_en[b] = wr_data[b] && (is_cause(b) || b == 15 || b == 16);
            end
            if (wr_en && !addr) begin
                for (int b = 0; b < 32; b++) if (wr_data[b] && is_cause(b)) m_cause[b] = 0;
                if (wr_data[13]) m_err = 0;
            end
            for (int b = 0; b < 32; b++) if (ev_pulse[b] && is_cause(b)) m_cause[b] = 1;
            if (ev_pulse[13]) m_err = int'(err_code);
            m_irq = nxt_irq;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        check(cur_req, rd_data, exp_read());
        check({cur_req, " irq (R10)"}, {31'b0, irq}, {31'b0, m_irq});
    end

    task automatic cyc(input logic w, input logic a, input logic [31:0] d, input logic [31:0] ev);
        @(negedge clk); #1;
        wr_en = w; addr = a; wr_data = d; ev_pulse = ev;
    endtask

    // Sample right after the edge that consumed the last cyc, then go idle.
    task automatic look(input string req, input logic [31:0] exp_word, input logic exp_irq);
        @(negedge clk);
        check(req, rd_data, exp_word);
        check({req, " irq"}, {31'b0, irq}, {31'b0, exp_irq});
        #1; wr_en = 1'b0; ev_pulse = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        cur_req = "R1";
        look("R1 status after reset", 32'h0, 1'b0);
        cyc(0, 1, 0, 0);
        look("R1 enable after reset", 32'h0, 1'b0);

        cur_req = "R5";
        cyc(1, 1, 32'hFFFF_FFFF, 0);
        look("R5 enable readback", 32'h0001_AFEF, 1'b0);
        cyc(1, 1, 32'h0, 0);
        look("R5 enable cleared", 32'h0, 1'b0);

        cur_req = "R2";
        cyc(0, 0, 0, 32'hFFFF_FFFF);
        look("R2 R11 all pulses", 32'h0000_2FEF, 1'b0);

        cur_req = "R3";
        cyc(1, 0, 32'h0000_0005, 0);
        look("R3 partial clear", 32'h0000_2FEA, 1'b0);
        @(negedge clk); snap = rd_data; #1;
        wr_en = 1'b1; addr = 1'b0; wr_data = snap;
        look("R3 write back read value", 32'h0, 1'b0);

        cur_req = "R6";
        cyc(1, 1, 32'h0001_0040, 0);
        look("R6 enable set", 32'h0001_0040, 1'b0);
        cyc(0, 0, 0, 32'h0000_0040);
        look("R6 normal summary", 32'h0001_0040, 1'b0);
        look("R10 irq one cycle later", 32'h0001_0040, 1'b1);
        cyc(0, 0, 0, 32'h0000_0002);
        look("R7 disabled cause no summary", 32'h0001_0042, 1'b1);

        cur_req = "R7";
        cyc(1, 1, 32'h0000_8002, 0);
        cyc(0, 0, 0, 0);
        look("R7 abnormal summary", 32'h0000_8042, 1'b1);

        cur_req = "R10";
        cyc(1, 1, 32'h0000_0002, 0);
        cyc(0, 0, 0, 0);
        look("R10 summary without its enable", 32'h0000_8042, 1'b0);

        cur_req = "R4";
        cyc(1, 0, 32'hFFFF_FFFF, 32'h0000_0080);
        look("R4 event beats clear", 32'h0000_0080, 1'b0);

        cur_req = "R8";
        rx_state = 3'd5; tx_state = 3'd3;
        look("R8 live states", 32'h003A_0080, 1'b0);
        cyc(1, 0, 32'h03FE_0000, 0);
        look("R8 R11 write to read-only", 32'h003A_0080, 1'b0);
        rx_state = 3'd0; tx_state = 3'd0;

        cur_req = "R9";
        err_code = 3'd6;
        cyc(0, 0, 0, 32'h0000_2000);
        look("R9 error capture", 32'h0300_2080, 1'b0);
        err_code = 3'd1;
        look("R9 error held", 32'h0300_2080, 1'b0);
        cyc(1, 0, 32'h0000_2000, 0);
        look("R9 error cleared", 32'h0000_0080, 1'b0);

        cur_req = "R3 random";
        for (int n = 0; n < RAND_CYCLES; n++) begin
            @(negedge clk); #1;
            wr_en    = ($urandom_range(0, 3) == 0);
            addr     = ($urandom_range(0, 4) == 0);
            wr_data  = $urandom;
            ev_pulse = $urandom & $urandom;
            rx_state = 3'($urandom);
            tx_state = 3'($urandom);
            err_code = 3'($urandom);
        end
        @(negedge clk); #1;
        wr_en = 0; ev_pulse = 0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule